// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out one atomic memory instruction at a time for a 32-bit core. The core hands over the 5-bit operation selector, the address taken from the first source register and the operand taken from the second. It also gives the base and byte size of the memory region that may be touched. The unit checks the address against that region. It then fetches the addressed word over a request/response memory port and computes the updated word. Where the operation calls for it, the unit writes that word back. It finishes with a one-cycle completion pulse that carries the destination value or a fault.

The operations are swap, add, the three bitwise combinations, signed and unsigned minimum and maximum, load-reserved and store-conditional. Load-reserved only reads. Store-conditional keeps no reservation and always writes and reports success. An address whose full word does not fit inside the region is rejected before any memory traffic. A selector value outside the supported set is reported as an illegal instruction, after the read and with no write.

Top module: `amo_unit`

## Requirements
- R1: `req_ready` is high only while the unit is idle. A request is taken when `req_valid` and `req_ready` are both high, and no further request is taken until the completion pulse of the current one.
- R2: Every in-window operation first issues exactly one read (`mem_req_write`=0) of the requested address. A memory request stays asserted with unchanged address, direction and write data until `mem_req_ready` is seen high.
- R3: Selectors 0x00 (add), 0x01 (swap), 0x04 (xor), 0x08 (or) and 0x0C (and) write the combination of the old word and the operand (for swap, the operand itself) back to the same address and return the old word.
- R4: Selector 0x10 writes the smaller and 0x14 the larger of old word and operand, both compared as two's-complement numbers, and returns the old word.
- R5: Selector 0x18 writes the smaller and 0x1C the larger of old word and operand, both compared as unsigned numbers, and returns the old word.
- R6: Selector 0x02 (load-reserved) returns the old word and issues no write.
- R7: Selector 0x03 (store-conditional) writes the operand unchanged and returns 0, whatever the memory held.
- R8: An address is inside the window when (address − base) mod 2^32, plus 4, does not exceed the window size. Outside it, the unit issues no memory request and completes with `fault`=1, `fault_code`=7, `fault_value` = the address and `result`=0.
- R9: Any other selector value is read but not written back. It completes with `fault`=1, `fault_code`=2, `fault_value`=0 and `result`=0.
- R10: Each accepted request produces exactly one `done` pulse, one cycle long. On a pulse without a fault, `fault` is 0.
- R11: While and right after reset, `req_ready`=1, `done`=0 and `mem_req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation offered |
| req_ready | output | 1 | Unit idle, can take an operation |
| req_funct5 | input | 5 | Operation selector |
| req_addr | input | 32 | Byte address of the word |
| req_operand | input | 32 | Second source operand |
| win_base | input | 32 | First byte address of the legal region |
| win_size | input | 32 | Byte size of the legal region |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Memory word address (byte units) |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Destination value, valid with `done` |
| fault | output | 1 | Operation faulted, valid with `done` |
| fault_code | output | 5 | 7 access fault, 2 illegal selector |
| fault_value | output | 32 | Faulting address or 0 |

## Verification
Minimum and maximum are driven with one negative and one small positive value. This pair alone separates signed from unsigned comparison, and swapped selectors or a dropped sign show at once. Add is run across 32-bit wrap, and the bitwise operations use overlapping bit patterns so that xor, or and and give distinct words. Window addresses sit at the last legal word, one word past the end, just below the base and far away with wrap, which pins the off-by-one and the modular offset. Random stalls on the request side and random read latency show that requests hold steady and that exactly the expected reads and writes reach memory.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int SEL_W   = 5;
  localparam int CAUSE_W = 5;

  localparam logic [SEL_W-1:0] SEL_ADD  = 5'h00;
  localparam logic [SEL_W-1:0] SEL_SWAP = 5'h01;
  localparam logic [SEL_W-1:0] SEL_LR   = 5'h02;
  localparam logic [SEL_W-1:0] SEL_SC   = 5'h03;
  localparam logic [SEL_W-1:0] SEL_XOR  = 5'h04;
  localparam logic [SEL_W-1:0] SEL_OR   = 5'h08;
  localparam logic [SEL_W-1:0] SEL_AND  = 5'h0C;
  localparam logic [SEL_W-1:0] SEL_MIN  = 5'h10;
  localparam logic [SEL_W-1:0] SEL_MAX  = 5'h14;
  localparam logic [SEL_W-1:0] SEL_MINU = 5'h18;
  localparam logic [SEL_W-1:0] SEL_MAXU = 5'h1C;

  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_ACCESS  = 5'd7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_CALC, ST_WR_REQ, ST_DONE
  } amo_state_e;
endpackage

// File: rtl/amo_window.sv
module amo_window #(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] size,
  output logic              hit
);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(BYTES);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W:0]   last_end;

  always_comb begin
    offset   = addr - base;
    last_end = {1'b0, offset} + SPAN;
    hit      = (last_end <= {1'b0, size});
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu import amo_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] new_word,
  output logic [DATA_W-1:0] dest_val,
  output logic              wants_write,
  output logic              legal
);
  function automatic logic below(input logic [DATA_W-1:0] a,
                                 input logic [DATA_W-1:0] b,
                                 input logic              as_signed);
    if (as_signed) return $signed(a) < $signed(b);
    return a < b;
  endfunction

  function automatic logic [DATA_W-1:0] lesser(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b,
                                               input logic              as_signed);
    return below(a, b, as_signed) ? a : b;
  endfunction

  function automatic logic [DATA_W-1:0] greater(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b,
                                                input logic              as_signed);
    return below(a, b, as_signed) ? b : a;
  endfunction

  always_comb begin
    new_word    = old_word;
    dest_val    = old_word;
    wants_write = 1'b1;
    legal       = 1'b1;
    case (sel)
      SEL_ADD:  new_word = old_word + operand;
      SEL_SWAP: new_word = operand;
      SEL_XOR:  new_word = old_word ^ operand;
      SEL_OR:   new_word = old_word | operand;
      SEL_AND:  new_word = old_word & operand;
      SEL_MIN:  new_word = lesser(operand, old_word, 1'b1);
      SEL_MAX:  new_word = greater(operand, old_word, 1'b1);
      SEL_MINU: new_word = lesser(operand, old_word, 1'b0);
      SEL_MAXU: new_word = greater(operand, old_word, 1'b0);
      SEL_LR:   wants_write = 1'b0;
      SEL_SC: begin
        new_word = operand;
        dest_val = '0;
      end
      default: begin
        legal       = 1'b0;
        wants_write = 1'b0;
        dest_val    = '0;
      end
    endcase
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit import amo_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [SEL_W-1:0]    req_funct5,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_operand,
  input  logic [ADDR_W-1:0]   win_base,
  input  logic [ADDR_W-1:0]   win_size,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [DATA_W-1:0]   mem_req_wdata,
  input  logic                mem_rsp_valid,
  input  logic [DATA_W-1:0]   mem_rsp_rdata,
  output logic                done,
  output logic [DATA_W-1:0]   result,
  output logic                fault,
  output logic [CAUSE_W-1:0]  fault_code,
  output logic [ADDR_W-1:0]   fault_value
);
  localparam int WORD_BYTES = DATA_W / 8;

  amo_state_e          state_q;
  logic [SEL_W-1:0]    op_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   rs2_q;
  logic [DATA_W-1:0]   old_q;
  logic [DATA_W-1:0]   new_q;
  logic [DATA_W-1:0]   res_q;
  logic                fault_q;
  logic [CAUSE_W-1:0]  code_q;
  logic [ADDR_W-1:0]   fval_q;

  // named events for the checker
  logic accept;
  logic win_hit;
  logic win_miss;
  logic rd_fire;
  logic wr_fire;

  logic [DATA_W-1:0] alu_new;
  logic [DATA_W-1:0] alu_dest;
  logic              alu_write;
  logic              alu_legal;

  amo_window #(.ADDR_W(ADDR_W), .BYTES(WORD_BYTES)) window_i (
    .addr (req_addr),
    .base (win_base),
    .size (win_size),
    .hit  (win_hit)
  );

  amo_alu #(.DATA_W(DATA_W)) alu_i (
    .sel         (op_q),
    .old_word    (old_q),
    .operand     (rs2_q),
    .new_word    (alu_new),
    .dest_val    (alu_dest),
    .wants_write (alu_write),
    .legal       (alu_legal)
  );

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    accept        = req_valid && req_ready;
    win_miss      = !win_hit;
    mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
    mem_req_write = (state_q == ST_WR_REQ);
    mem_req_addr  = addr_q;
    mem_req_wdata = new_q;
    rd_fire       = (state_q == ST_RD_REQ) && mem_req_ready;
    wr_fire       = (state_q == ST_WR_REQ) && mem_req_ready;
    done          = (state_q == ST_DONE);
    result        = res_q;
    fault         = fault_q;
    fault_code    = code_q;
    fault_value   = fval_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      rs2_q   <= '0;
      old_q   <= '0;
      new_q   <= '0;
      res_q   <= '0;
      fault_q <= 1'b0;
      code_q  <= '0;
      fval_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_q   <= req_funct5;
            addr_q <= req_addr;
            rs2_q  <= req_operand;
            res_q  <= '0;
            if (win_miss) begin
              fault_q <= 1'b1;
              code_q  <= CAUSE_ACCESS;
              fval_q  <= req_addr;
              state_q <= ST_DONE;
            end else begin
              fault_q <= 1'b0;
              code_q  <= '0;
              fval_q  <= '0;
              state_q <= ST_RD_REQ;
            end
          end
        end
        ST_RD_REQ: begin
          if (rd_fire) state_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (mem_rsp_valid) begin
            old_q   <= mem_rsp_rdata;
            state_q <= ST_CALC;
          end
        end
        ST_CALC: begin
          new_q <= alu_new;
          res_q <= alu_dest;
          if (!alu_legal) begin
            fault_q <= 1'b1;
            code_q  <= CAUSE_ILLEGAL;
            fval_q  <= '0;
            state_q <= ST_DONE;
          end else if (alu_write) begin
            state_q <= ST_WR_REQ;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_WR_REQ: begin
          if (wr_fire) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk import amo_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               accept,
  input logic               win_miss,
  input logic [SEL_W-1:0]   op_q,
  input logic [DATA_W-1:0]  rs2_q,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic               mem_req_write,
  input logic [ADDR_W-1:0]  mem_req_addr,
  input logic [DATA_W-1:0]  mem_req_wdata,
  input logic               done,
  input logic               fault,
  input logic [CAUSE_W-1:0] fault_code
);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !done);

  assert_miss_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && win_miss |=> done && fault && fault_code == CAUSE_ACCESS && !mem_req_valid);

  assert_lr_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> op_q != SEL_LR);

  assert_sc_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write && op_q == SEL_SC |-> mem_req_wdata == rs2_q);

  assert_fault_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> fault_code == CAUSE_ACCESS || fault_code == CAUSE_ILLEGAL);
endmodule

bind amo_unit amo_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .accept        (accept),
  .win_miss      (win_miss),
  .op_q          (op_q),
  .rs2_q         (rs2_q),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .done          (done),
  .fault         (fault),
  .fault_code    (fault_code)
);

// File: tb/amo_unit_tb_top.sv
`timescale 1ns/1ps
module amo_unit_tb_top;
  localparam logic [31:0] BASE = 32'h8000_0000;
  localparam logic [31:0] SIZE = 32'h0000_0040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_funct5 = '0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_operand = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        done;
  logic [31:0] result;
  logic        fault;
  logic [4:0]  fault_code;
  logic [31:0] fault_value;

  always #2.5 clk = ~clk;

  amo_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_funct5(req_funct5),
    .req_addr(req_addr), .req_operand(req_operand),
    .win_base(BASE), .win_size(SIZE),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .done(done), .result(result), .fault(fault),
    .fault_code(fault_code), .fault_value(fault_value)
  );

  int tests = 0;
  int fails = 0;

  // bench memory and reference state
  logic [31:0] bmem [16];
  logic [64:0] exp_q [$];
  logic        exp_pending = 1'b0;
  logic [31:0] exp_result;
  logic        exp_fault;
  logic [4:0]  exp_code;
  logic [31:0] exp_fval;
  string       cur_req = "";
  logic        done_seen = 1'b0;
  logic        busy = 1'b0;
  logic [7:0]  lfsr = 8'hA5;
  logic        rsp_pending = 1'b0;
  int          rsp_delay = 0;
  logic [31:0] rsp_word = '0;
  logic        stall_heavy = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  function automatic bit in_window(input logic [31:0] a);
    logic [31:0] off;
    off = a - BASE;
    return off <= SIZE - 32'd4;
  endfunction

  // per-clock monitor and memory model
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (rsp_pending) begin
        if (rsp_delay == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = rsp_word;
          rsp_pending = 1'b0;
        end else rsp_delay--;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_req_ready = stall_heavy ? (lfsr[0] & lfsr[1]) : (lfsr[0] | lfsr[2]);
      #1;
      if (busy && req_ready) chk(1'b0, "R1", "ready while busy", 32'(req_ready), 0);
      if (mem_req_valid && mem_req_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_req, "unexpected memory request",
              {mem_req_write, mem_req_addr[30:0]}, 0);
        end else begin
          logic [64:0] e;
          e = exp_q.pop_front();
          chk(mem_req_write == e[64], "R2", "request direction",
              32'(mem_req_write), 32'(e[64]));
          chk(mem_req_addr == e[63:32], "R2", "request address", mem_req_addr, e[63:32]);
          if (e[64]) begin
            chk(mem_req_wdata == e[31:0], cur_req, "write data", mem_req_wdata, e[31:0]);
            bmem[4'((mem_req_addr - BASE) >> 2)] = mem_req_wdata;
          end else begin
            rsp_word    = bmem[4'((mem_req_addr - BASE) >> 2)];
            rsp_pending = 1'b1;
            rsp_delay   = int'(lfsr[4:3]);
          end
        end
      end
      if (done) begin
        chk(exp_pending, "R10", "done without request", 32'(done), 0);
        chk(result == exp_result, cur_req, "result", result, exp_result);
        chk(fault == exp_fault, cur_req, "fault", 32'(fault), 32'(exp_fault));
        if (exp_fault) begin
          chk(fault_code == exp_code, cur_req, "fault code", 32'(fault_code), 32'(exp_code));
          chk(fault_value == exp_fval, cur_req, "fault value", fault_value, exp_fval);
        end
        chk(exp_q.size() == 0, "R2", "memory requests missing", exp_q.size(), 0);
        exp_pending = 1'b0;
        busy        = 1'b0;
        done_seen   = 1'b1;
      end
    end
  end

  task automatic run_op(input logic [4:0] sel, input logic [31:0] addr,
                        input logic [31:0] opnd, input string req);
    logic [31:0] old_w, new_w;
    bit wr, legal;
    @(negedge clk);
    chk(req_ready, "R1", "ready before issue", 32'(req_ready), 1);
    cur_req = req;
    exp_q.delete();
    exp_fault = 1'b0; exp_code = '0; exp_fval = '0;
    if (!in_window(addr)) begin
      exp_fault = 1'b1; exp_code = 5'd7; exp_fval = addr; exp_result = '0;
    end else begin
      old_w = bmem[4'((addr - BASE) >> 2)];
      wr = 1'b1; legal = 1'b1; new_w = old_w; exp_result = old_w;
      case (sel)
        5'h00: new_w = old_w + opnd;
        5'h01: new_w = opnd;
        5'h04: new_w = old_w ^ opnd;
        5'h08: new_w = old_w | opnd;
        5'h0C: new_w = old_w & opnd;
        5'h10: new_w = ($signed(opnd) < $signed(old_w)) ? opnd : old_w;
        5'h14: new_w = ($signed(opnd) > $signed(old_w)) ? opnd : old_w;
        5'h18: new_w = (opnd < old_w) ? opnd : old_w;
        5'h1C: new_w = (opnd > old_w) ? opnd : old_w;
        5'h02: wr = 1'b0;
        5'h03: begin new_w = opnd; exp_result = '0; end
        default: begin legal = 1'b0; wr = 1'b0; end
      endcase
      exp_q.push_back({1'b0, addr, 32'h0});
      if (wr) exp_q.push_back({1'b1, addr, new_w});
      if (!legal) begin
        exp_fault = 1'b1; exp_code = 5'd2; exp_fval = '0; exp_result = '0;
      end
    end
    exp_pending = 1'b1;
    done_seen   = 1'b0;
    req_valid = 1'b1; req_funct5 = sel; req_addr = addr; req_operand = opnd;
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    if (!done_seen) busy = 1'b1;
    for (int i = 0; i < 400 && !done_seen; i++) begin
      @(negedge clk);
      #2;
    end
    if (!done_seen) begin
      chk(1'b0, req, "watchdog: no done", 0, 1);
      exp_pending = 1'b0;
      busy = 1'b0;
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) bmem[i] = 32'h1000_0000 + 32'(i);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready in reset", 32'(req_ready), 1);
    chk(done == 1'b0, "R11", "done in reset", 32'(done), 0);
    chk(mem_req_valid == 1'b0, "R11", "mem valid in reset", 32'(mem_req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && mem_req_valid == 1'b0, "R11",
        "idle after reset", {req_ready, done, mem_req_valid}, 32'h4);

    bmem[0] = 32'd5;            run_op(5'h00, BASE + 0,  32'd7,        "R3 add");
    bmem[1] = 32'hFFFF_FFFF;    run_op(5'h00, BASE + 4,  32'd1,        "R3 add wrap");
    bmem[2] = 32'hDEAD_BEEF;    run_op(5'h01, BASE + 8,  32'h0BAD_F00D, "R3 swap");
    bmem[3] = 32'hF0F0_FF00;    run_op(5'h04, BASE + 12, 32'hFF00_F0F0, "R3 xor");
    bmem[3] = 32'hF0F0_FF00;    run_op(5'h08, BASE + 12, 32'hFF00_F0F0, "R3 or");
    bmem[3] = 32'hF0F0_FF00;    run_op(5'h0C, BASE + 12, 32'hFF00_F0F0, "R3 and");
    bmem[4] = 32'hFFFF_FFFE;    run_op(5'h10, BASE + 16, 32'd3,        "R4 min signed");
    bmem[4] = 32'hFFFF_FFFE;    run_op(5'h14, BASE + 16, 32'd3,        "R4 max signed");
    bmem[4] = 32'hFFFF_FFFE;    run_op(5'h18, BASE + 16, 32'd3,        "R5 min unsigned");
    bmem[4] = 32'hFFFF_FFFE;    run_op(5'h1C, BASE + 16, 32'd3,        "R5 max unsigned");
    bmem[5] = 32'h8000_0000;    run_op(5'h10, BASE + 20, 32'h7FFF_FFFF, "R4 min extremes");
    bmem[6] = 32'h1234_5678;    run_op(5'h02, BASE + 24, 32'hAAAA_AAAA, "R6 load-reserved");
    chk(bmem[6] == 32'h1234_5678, "R6", "memory after LR", bmem[6], 32'h1234_5678);
    bmem[7] = 32'h5555_5555;    run_op(5'h03, BASE + 28, 32'hCAFE_0001, "R7 store-cond");
    chk(bmem[7] == 32'hCAFE_0001, "R7", "memory after SC", bmem[7], 32'hCAFE_0001);
    stall_heavy = 1'b1;
    bmem[15] = 32'd100;         run_op(5'h00, BASE + 60, 32'd23,       "R8 last word");
    chk(bmem[15] == 32'd123, "R8", "last word updated", bmem[15], 32'd123);
    run_op(5'h00, BASE + 64,        32'd1, "R8 past end");
    run_op(5'h01, BASE - 4,         32'd1, "R8 below base");
    run_op(5'h03, 32'h0000_0000,    32'd1, "R8 wrapped offset");
    bmem[8] = 32'h0000_00AA;    run_op(5'h05, BASE + 32, 32'd9,        "R9 illegal");
    chk(bmem[8] == 32'h0000_00AA, "R9", "memory after illegal", bmem[8], 32'h0000_00AA);
    run_op(5'h1F, BASE + 32, 32'd9, "R9 illegal high");
    stall_heavy = 1'b0;
    bmem[9] = 32'h0000_0010;    run_op(5'h1C, BASE + 36, 32'h0000_0020, "R5 maxu back-to-back");
    run_op(5'h18, BASE + 36, 32'h0000_0001, "R5 minu back-to-back");
    chk(bmem[9] == 32'h0000_0001, "R5", "memory after minu", bmem[9], 32'h1);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule